// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block sits between a host register bus and the byte-wide handshake engine of a parallel port that runs in enhanced (address/data strobe) mode. The host reads and writes a small set of register indexes. Accesses to the address port and the data port pass through only when the control register holds the exact pattern for the direction of the access. An access that passes becomes one or more byte requests on a downstream request/acknowledge interface. An access that does not pass finishes at once and moves nothing.

The downstream side answers each byte with an acknowledge or a timeout. A timeout stops the access and sets a sticky flag. Software sees this flag in bit 0 of the status register and clears it by writing that bit. Data-port accesses may be one, two or four bytes wide. Wider ones are broken into single bytes, least significant first. The block also holds the control register and drives the control lines and a separate data-direction output from it.

Top module: `pp_epp_gate`

## Requirements
- R1: After reset the control register reads 0x0C, the control lines are 0x0C, the direction output is 0, the timeout flag is 0, and neither a downstream request nor a host ready is active.
- R2: Index 3 is the address port and index 4 is the data port. Every byte of an index 3 access drives dn_sel_addr=1, and every byte of an index 4 access drives dn_sel_addr=0. An index 3 access always moves exactly one byte, whatever its size.
- R3: A write to index 3 or 4 is forwarded only when control bits {5,3,2,1,0} equal 0b00100 (mask 0x2F gives 0x04). Any other write to index 3 or 4 completes without a downstream request.
- R4: A read from index 3 or 4 is forwarded only when control bits {5,3,2,1,0} equal 0b10100 (mask 0x2F gives 0x24). Any other read completes without a downstream request.
- R5: host_size 0, 1 and 2 select 1, 2 and 4 bytes on the data port. Byte i goes out, or is returned, on bits [8i+7:8i], with byte 0 first. The unused upper read bits are 0.
- R6: A downstream timeout on any byte ends the access at once, so no further bytes are requested, and sets the timeout flag. The flag stays set until software clears it.
- R7: A status read (index 1) returns st_lines bits 7..1 in bits 7..1 and the timeout flag in bit 0. The st_lines bit 0 value is ignored.
- R8: A status write with bit 0 = 1 clears the timeout flag. A status write with bit 0 = 0 leaves it unchanged.
- R9: A control write (index 2) whose value equals the current control value does nothing: ctl_load stays 0 and the lines do not change.
- R10: A control write that changes the value updates the control register. It drives dir_out with bit 5, drives ctl_lines with the value with bit 5 forced to 0, and pulses ctl_load in the cycle that host_ready is high.
- R11: A rejected or timed-out read from index 3 or 4 returns all ones across the access width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R12: At most one downstream byte is outstanding. host_ready pulses for exactly one cycle, in the cycle after the last byte's acknowledge or timeout, or in the cycle after the request for a register access or a rejected access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_idx | input | 3 | Register index |
| host_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data, valid while host_ready is high |
| host_ready | output | 1 | One-cycle completion pulse |
| st_lines | input | 8 | Status lines from the port |
| ctl_lines | output | 8 | Control lines to the port |
| dir_out | output | 1 | Data-direction output (1 = inbound) |
| ctl_load | output | 1 | Pulse when the control lines take a new value |
| dn_req | output | 1 | Downstream byte request |
| dn_we | output | 1 | Downstream byte is a write |
| dn_sel_addr | output | 1 | Downstream byte targets the address strobe |
| dn_wbyte | output | 8 | Downstream write byte |
| dn_rbyte | input | 8 | Downstream read byte, valid with dn_ack |
| dn_ack | input | 1 | Downstream byte done |
| dn_tmo | input | 1 | Downstream byte timed out |

## Verification
A wrong control register or a wrong qualifier result shows up at the ports on the next gated access. A request appears where none should, or none appears where one should, and a rejected read returns ones instead of data. A byte counter that is off by one shows up when the access completes. The number of acknowledged bytes, the byte order on dn_wbyte, or the assembled read word is wrong when host_ready rises. A lost or stuck timeout flag shows up on the very next status read.

// File: rtl/pp_epp_pkg.sv
package pp_epp_pkg;
  localparam logic [2:0] IDX_STS  = 3'd1;
  localparam logic [2:0] IDX_CTL  = 3'd2;
  localparam logic [2:0] IDX_EADR = 3'd3;
  localparam logic [2:0] IDX_EDAT = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTL_RESET  = 8'h0C;
  localparam int         DIR_BIT    = 5;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_RESP = 2'd2
  } host_st_e;
endpackage

// File: rtl/pp_epp_qual.sv
module pp_epp_qual
  import pp_epp_pkg::*;
(
  input  logic [7:0] ctl,
  input  logic       is_write,
  output logic       ok
);
  logic [7:0] want;

  always_comb begin
    want = is_write ? GATE_WR : GATE_RD;
    ok   = ((ctl & GATE_MASK) == want);
  end
endmodule

// File: rtl/pp_epp_seq.sv
module pp_epp_seq #(
  parameter int DW = 32,
  parameter int CW = $clog2(DW/8 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we,
  input  logic          sel_addr,
  input  logic [CW-1:0] nbytes,
  input  logic [DW-1:0] wdata,
  input  logic          dn_ack,
  input  logic          dn_tmo,
  input  logic [7:0]    dn_rbyte,
  output logic          dn_req,
  output logic          dn_we,
  output logic          dn_sel_addr,
  output logic [7:0]    dn_wbyte,
  output logic          fin,
  output logic          fin_err,
  output logic [DW-1:0] rd_word
);
  localparam int NB = DW / 8;

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] nb_q, nb_d;
  logic          we_q, we_d;
  logic          sel_q, sel_d;
  logic [DW-1:0] wd_q, wd_d;
  logic [DW-1:0] acc_q, acc_d;
  logic          step;

  assign step        = run_q && (dn_ack || dn_tmo);
  assign fin         = step && (dn_tmo || (cnt_q == nb_q - CW'(1)));
  assign fin_err     = step && dn_tmo;
  assign dn_req      = run_q;
  assign dn_we       = we_q;
  assign dn_sel_addr = sel_q;
  assign rd_word     = acc_d;

  always_comb begin
    dn_wbyte = '0;
    for (int i = 0; i < NB; i++) begin
      if (cnt_q == CW'(i)) dn_wbyte = wd_q[8*i +: 8];
    end
  end

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    nb_d  = nb_q;
    we_d  = we_q;
    sel_d = sel_q;
    wd_d  = wd_q;
    acc_d = acc_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
      nb_d  = nbytes;
      we_d  = we;
      sel_d = sel_addr;
      wd_d  = wdata;
      acc_d = '0;
    end else if (step) begin
      for (int i = 0; i < NB; i++) begin
        if (cnt_q == CW'(i) && !dn_tmo) acc_d[8*i +: 8] = dn_rbyte;
      end
      if (fin) run_d = 1'b0;
      else     cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      nb_q  <= '0;
      we_q  <= 1'b0;
      sel_q <= 1'b0;
      wd_q  <= '0;
      acc_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      nb_q  <= nb_d;
      we_q  <= we_d;
      sel_q <= sel_d;
      wd_q  <= wd_d;
      acc_q <= acc_d;
    end
  end

  // R12: the byte counter never runs past the access length
  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < nb_q));
  // R12: no new access starts while a byte is outstanding
  p_start_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);
endmodule

// File: rtl/pp_epp_gate.sv
module pp_epp_gate
  import pp_epp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  logic          host_we,
  input  logic [2:0]    host_idx,
  input  logic [1:0]    host_size,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_ready,
  input  logic [7:0]    st_lines,
  output logic [7:0]    ctl_lines,
  output logic          dir_out,
  output logic          ctl_load,
  output logic          dn_req,
  output logic          dn_we,
  output logic          dn_sel_addr,
  output logic [7:0]    dn_wbyte,
  input  logic [7:0]    dn_rbyte,
  input  logic          dn_ack,
  input  logic          dn_tmo
);
  localparam int NB = DW / 8;
  localparam int CW = $clog2(NB + 1);

  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  host_st_e      st_q, st_d;
  logic [7:0]    ctl_q, ctl_d;
  logic [7:0]    lines_q, lines_d;
  logic          dir_q, dir_d;
  logic          load_q, load_d;
  logic          tmo_q, tmo_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [DW-1:0] mask_q, mask_d;

  logic          is_epp, gate_ok, seq_start;
  logic [CW-1:0] nb_dec;
  logic          seq_fin, seq_err;
  logic [DW-1:0] seq_rd;

  pp_epp_qual u_qual (
    .ctl      (ctl_q),
    .is_write (host_we),
    .ok       (gate_ok)
  );

  pp_epp_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sn),
    .start       (seq_start),
    .we          (host_we),
    .sel_addr    (host_idx == IDX_EADR),
    .nbytes      (nb_dec),
    .wdata       (host_wdata),
    .dn_ack      (dn_ack),
    .dn_tmo      (dn_tmo),
    .dn_rbyte    (dn_rbyte),
    .dn_req      (dn_req),
    .dn_we       (dn_we),
    .dn_sel_addr (dn_sel_addr),
    .dn_wbyte    (dn_wbyte),
    .fin         (seq_fin),
    .fin_err     (seq_err),
    .rd_word     (seq_rd)
  );

  assign is_epp = (host_idx == IDX_EADR) || (host_idx == IDX_EDAT);

  always_comb begin
    if (host_idx == IDX_EADR) nb_dec = CW'(1);
    else begin
      case (host_size)
        2'd0:    nb_dec = CW'(1);
        2'd1:    nb_dec = CW'(2);
        default: nb_dec = CW'(4);
      endcase
    end
    if (nb_dec > CW'(NB)) nb_dec = CW'(NB);
  end

  always_comb begin
    mask_d = '0;
    for (int i = 0; i < NB; i++) begin
      if (CW'(i) < nb_dec) mask_d[8*i +: 8] = 8'hFF;
    end
  end

  always_comb begin
    st_d      = st_q;
    ctl_d     = ctl_q;
    lines_d   = lines_q;
    dir_d     = dir_q;
    load_d    = 1'b0;
    tmo_d     = tmo_q;
    rdata_d   = rdata_q;
    seq_start = 1'b0;
    case (st_q)
      HS_IDLE: begin
        if (host_valid) begin
          rdata_d = '0;
          if (is_epp && gate_ok) begin
            seq_start = 1'b1;
            st_d      = HS_WAIT;
          end else begin
            st_d = HS_RESP;
            if (!host_we) begin
              if (is_epp)                rdata_d = mask_d;
              else if (host_idx == IDX_STS) rdata_d = DW'({st_lines[7:1], tmo_q});
              else if (host_idx == IDX_CTL) rdata_d = DW'(ctl_q);
            end else if (host_idx == IDX_STS) begin
              if (host_wdata[0]) tmo_d = 1'b0;
            end else if (host_idx == IDX_CTL && host_wdata[7:0] != ctl_q) begin
              ctl_d   = host_wdata[7:0];
              dir_d   = host_wdata[DIR_BIT];
              lines_d = host_wdata[7:0] & ~(8'(1) << DIR_BIT);
              load_d  = 1'b1;
            end
          end
        end
      end
      HS_WAIT: begin
        if (seq_fin) begin
          st_d = HS_RESP;
          if (seq_err) tmo_d = 1'b1;
          if (dn_we)        rdata_d = '0;
          else if (seq_err) rdata_d = mask_q;
          else              rdata_d = seq_rd;
        end
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q    <= HS_IDLE;
      ctl_q   <= CTL_RESET;
      lines_q <= CTL_RESET;
      dir_q   <= 1'b0;
      load_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rdata_q <= '0;
      mask_q  <= '0;
    end else begin
      st_q    <= st_d;
      ctl_q   <= ctl_d;
      lines_q <= lines_d;
      dir_q   <= dir_d;
      load_q  <= load_d;
      tmo_q   <= tmo_d;
      rdata_q <= rdata_d;
      if (seq_start) mask_q <= mask_d;
    end
  end

  assign host_rdata = rdata_q;
  assign host_ready = (st_q == HS_RESP);
  assign ctl_lines  = lines_q;
  assign dir_out    = dir_q;
  assign ctl_load   = load_q;

  // R12: a downstream byte is only requested while the host waits
  p_one_xfer_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    dn_req |-> (st_q == HS_WAIT));
  // R12: completion is a single-cycle pulse
  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    host_ready |=> !host_ready);
  // R6: a downstream timeout leaves the flag set
  p_tmo_sticky_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (dn_req && dn_tmo) |=> tmo_q);
  // R3: forwarded writes only under the write pattern
  p_wgate_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (dn_req && dn_we) |-> ((ctl_q & GATE_MASK) == GATE_WR));
  // R4: forwarded reads only under the read pattern
  p_rgate_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (dn_req && !dn_we) |-> ((ctl_q & GATE_MASK) == GATE_RD));
  // R9: a load pulse always follows a real change of control
  p_load_change_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    ctl_load |-> (ctl_q != $past(ctl_q)));
endmodule

// File: tb/pp_epp_gate_tb.sv
module pp_epp_gate_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_valid, host_we;
  logic [2:0]    host_idx;
  logic [1:0]    host_size;
  logic [DW-1:0] host_wdata, host_rdata;
  logic          host_ready;
  logic [7:0]    st_lines, ctl_lines;
  logic          dir_out, ctl_load;
  logic          dn_req, dn_we, dn_sel_addr;
  logic [7:0]    dn_wbyte, dn_rbyte;
  logic          dn_ack, dn_tmo;

  always #2ns clk = ~clk;

  pp_epp_gate #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_we(host_we), .host_idx(host_idx),
    .host_size(host_size), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .st_lines(st_lines), .ctl_lines(ctl_lines),
    .dir_out(dir_out), .ctl_load(ctl_load), .dn_req(dn_req), .dn_we(dn_we),
    .dn_sel_addr(dn_sel_addr), .dn_wbyte(dn_wbyte), .dn_rbyte(dn_rbyte),
    .dn_ack(dn_ack), .dn_tmo(dn_tmo)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  int resp_delay = 1;
  int tmo_at = -1;
  int wcnt = 0;
  int nlog = 0;
  logic [7:0] log_byte [8];
  logic       log_sel  [8];
  logic       log_we   [8];

  typedef struct packed {
    logic        we;
    logic [2:0]  idx;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [3:0]  nb;
    logic [23:0] tag;
  } vec_t;

  localparam vec_t VT [16] = '{
    '{1'b0, 3'd2, 2'd0, 32'h0,        32'h0000000C, 4'd0, "R1 "},
    '{1'b0, 3'd1, 2'd0, 32'h0,        32'h0000005A, 4'd0, "R7 "},
    '{1'b1, 3'd4, 2'd0, 32'h11,       32'h0,        4'd0, "R3 "},
    '{1'b1, 3'd2, 2'd0, 32'h04,       32'h0,        4'd0, "R10"},
    '{1'b1, 3'd4, 2'd2, 32'h44332211, 32'h0,        4'd4, "R5 "},
    '{1'b1, 3'd3, 2'd0, 32'h5A,       32'h0,        4'd1, "R2 "},
    '{1'b0, 3'd4, 2'd0, 32'h0,        32'h000000FF, 4'd0, "R4 "},
    '{1'b1, 3'd2, 2'd0, 32'h24,       32'h0,        4'd0, "R10"},
    '{1'b0, 3'd3, 2'd0, 32'h0,        32'h000000A0, 4'd1, "R2 "},
    '{1'b0, 3'd4, 2'd1, 32'h0,        32'h0000A1A0, 4'd2, "R5 "},
    '{1'b0, 3'd4, 2'd2, 32'h0,        32'hA3A2A1A0, 4'd4, "R5 "},
    '{1'b1, 3'd3, 2'd0, 32'h77,       32'h0,        4'd0, "R3 "},
    '{1'b0, 3'd3, 2'd2, 32'h0,        32'h000000A0, 4'd1, "R2 "},
    '{1'b1, 3'd2, 2'd0, 32'h2C,       32'h0,        4'd0, "R4 "},
    '{1'b0, 3'd4, 2'd2, 32'h0,        32'hFFFFFFFF, 4'd0, "R11"},
    '{1'b1, 3'd2, 2'd0, 32'h24,       32'h0,        4'd0, "R10"}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [2:0] idx, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output logic ld, output int cyc);
    @(negedge clk);
    nlog = 0;
    wcnt = 0;
    host_valid = 1'b1;
    host_we    = we;
    host_idx   = idx;
    host_size  = sz;
    host_wdata = wd;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (host_ready) break;
      if (cyc > 2000) begin
        chk(1'b0, "R12 ready", 32'(cyc), 32'd0);
        break;
      end
    end
    rd = host_rdata;
    ld = ctl_load;
    host_valid = 1'b0;
  endtask

  // downstream responder
  initial begin
    dn_ack = 1'b0;
    dn_tmo = 1'b0;
    dn_rbyte = 8'h00;
    forever begin
      @(negedge clk);
      if (dn_ack || dn_tmo) begin
        dn_ack = 1'b0;
        dn_tmo = 1'b0;
      end else if (dn_req) begin
        wcnt++;
        if (wcnt >= resp_delay) begin
          wcnt = 0;
          if (nlog < 8) begin
            log_byte[nlog] = dn_wbyte;
            log_sel[nlog]  = dn_sel_addr;
            log_we[nlog]   = dn_we;
          end
          dn_rbyte = 8'hA0 + 8'(nlog);
          if (nlog == tmo_at) dn_tmo = 1'b1;
          else                dn_ack = 1'b1;
          nlog++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        ld;
    int          cyc;
    host_valid = 1'b0;
    host_we    = 1'b0;
    host_idx   = '0;
    host_size  = '0;
    host_wdata = '0;
    st_lines   = 8'h5B;
    rst_n      = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state at the ports
    chk(ctl_lines == 8'h0C, "R1 lines", 32'(ctl_lines), 32'h0C);
    chk(dir_out == 1'b0, "R1 dir", 32'(dir_out), 32'h0);
    chk(!dn_req && !host_ready, "R1 idle", {30'd0, dn_req, host_ready}, 32'h0);

    for (int i = 0; i < 16; i++) begin
      acc(VT[i].we, VT[i].idx, VT[i].sz, VT[i].wd, rd, ld, cyc);
      chk(rd == VT[i].rd, $sformatf("%s vec%0d rdata", VT[i].tag, i), rd, VT[i].rd);
      chk(nlog == int'(VT[i].nb), $sformatf("%s vec%0d bytes", VT[i].tag, i), 32'(nlog), 32'(VT[i].nb));
      for (int j = 0; j < int'(VT[i].nb) && j < nlog; j++) begin
        chk(log_sel[j] == (VT[i].idx == 3'd3), $sformatf("R2 vec%0d sel%0d", i, j),
            32'(log_sel[j]), 32'(VT[i].idx == 3'd3));
        chk(log_we[j] == VT[i].we, $sformatf("%s vec%0d dir%0d", VT[i].tag, i, j),
            32'(log_we[j]), 32'(VT[i].we));
        if (VT[i].we)
          chk(log_byte[j] == VT[i].wd[8*j +: 8], $sformatf("R5 vec%0d byte%0d", i, j),
              32'(log_byte[j]), 32'(VT[i].wd[8*j +: 8]));
      end
    end

    // R9: equal control write is ignored
    acc(1'b1, 3'd2, 2'd0, 32'h24, rd, ld, cyc);
    chk(ld == 1'b0, "R9 load", 32'(ld), 32'h0);
    chk(ctl_lines == 8'h04, "R9 lines", 32'(ctl_lines), 32'h04);

    // R6 / R11: timeout on second byte of a 4-byte read
    tmo_at = 1;
    acc(1'b0, 3'd4, 2'd2, 32'h0, rd, ld, cyc);
    tmo_at = -1;
    chk(rd == 32'hFFFFFFFF, "R11 tmo read", rd, 32'hFFFFFFFF);
    chk(nlog == 2, "R6 abort", 32'(nlog), 32'd2);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, ld, cyc);
    chk(rd == 32'h5B, "R7 flag set", rd, 32'h5B);

    // R8: clear only with bit 0 set
    acc(1'b1, 3'd1, 2'd0, 32'hFE, rd, ld, cyc);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, ld, cyc);
    chk(rd == 32'h5B, "R8 keep", rd, 32'h5B);
    acc(1'b1, 3'd1, 2'd0, 32'h01, rd, ld, cyc);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, ld, cyc);
    chk(rd == 32'h5A, "R8 clear", rd, 32'h5A);

    // R12: slow downstream, ready only after the last ack
    resp_delay = 4;
    acc(1'b0, 3'd4, 2'd1, 32'h0, rd, ld, cyc);
    chk(rd == 32'h0000A1A0, "R12 slow data", rd, 32'h0000A1A0);
    chk(cyc >= 8, "R12 latency", 32'(cyc), 32'd8);
    @(negedge clk);
    chk(host_ready == 1'b0, "R12 pulse", 32'(host_ready), 32'h0);
    resp_delay = 1;

    // R10: control change toggles direction and lines
    acc(1'b1, 3'd2, 2'd0, 32'h0C, rd, ld, cyc);
    chk(ld && dir_out == 1'b0 && ctl_lines == 8'h0C, "R10 to out",
        {ld, dir_out, 22'd0, ctl_lines}, {2'b10, 22'd0, 8'h0C});
    acc(1'b1, 3'd2, 2'd0, 32'h04, rd, ld, cyc);
    chk(ld == 1'b1, "R10 load", 32'(ld), 32'h1);
    acc(1'b1, 3'd2, 2'd0, 32'h34, rd, ld, cyc);
    chk(dir_out == 1'b1 && ctl_lines == 8'h14, "R10 to in",
        {23'd0, dir_out, ctl_lines}, {23'd0, 1'b1, 8'h14});
    acc(1'b1, 3'd2, 2'd0, 32'h04, rd, ld, cyc);

    // R11: rejected 2-byte read under the write pattern
    acc(1'b0, 3'd4, 2'd1, 32'h0, rd, ld, cyc);
    chk(rd == 32'h0000FFFF, "R11 reject", rd, 32'h0000FFFF);
    chk(nlog == 0, "R4 no req", 32'(nlog), 32'd0);

    // R6: write timeout on first byte stops the access
    tmo_at = 0;
    acc(1'b1, 3'd4, 2'd1, 32'hBEEF, rd, ld, cyc);
    tmo_at = -1;
    chk(nlog == 1, "R6 write abort", 32'(nlog), 32'd1);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, ld, cyc);
    chk(rd[0] == 1'b1, "R6 write flag", 32'(rd[0]), 32'h1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule